// File: doc/BRIEF.md
# PUF Aging Calibration Sequencer

This controller steers the post-fabrication tuning of an SRAM start-up fingerprint array. It controls the array through a plain synchronous read/write port and an external power-and-stress unit through two request/done handshakes. A calibration run starts with a start pulse. The block first power-cycles the array and counts the ones in the start-up pattern. While that count lies outside a programmable window, it requests a stress period followed by a fresh power-up and recount. A stress period applied while each cell holds its own start-up value drifts the array's balance.

Once the balance target is met, the reliability loop starts. One power-up supplies a reference pattern, which is kept in an internal buffer. A programmable number of further power-ups are each compared against that reference, and the differing bit positions are summed. If the sum exceeds a limit, the block writes the complement of the reference into every word and then requests stress. A cell held at the opposite value during stress is pushed toward its original start-up value. Each loop has a programmable iteration limit. Reaching a limit ends the run with a fail flag and a phase code.

The block has no streaming data path, so it has no valid/ready interface. Array reads have a fixed one-cycle latency and are never back-pressured. The two handshakes are level request / pulse done.

Top module: `puf_tune_seq`

## Requirements
- R1: The configuration inputs are captured on the cycle `start` is sampled while idle. Later changes to them and further `start` pulses have no effect until `done` rises.
- R2: `pwr_req` and `stress_req` stay high until their own done input is seen. A done input is ignored while its request is low. The two requests are never high together, and neither is high while idle.
- R3: A scan raises `arr_rd_en` for addresses 0 to DEPTH-1 in consecutive cycles. Read data is taken one cycle after each read. Bit j of word k is pattern bit k*W+j. `ones_cnt` shows the ones counted in the latest balance scan.
- R4: If the ones count lies in [`cfg_win_lo`, `cfg_win_hi`], both bounds included, no stress is requested in the balance phase.
- R5: Otherwise the block repeats stress, power-up and recount until the count is inside the window. `uni_iters` counts these stress periods.
- R6: If the count is still outside the window when `uni_iters` equals `cfg_uni_max`, the run ends with `fail`=1 and `fail_phase`=2'b01.
- R7: The reliability phase begins only after the window is met. Each round is one reference power-up plus `cfg_pwrups` compare power-ups. `var_sum` is the sum of Hamming distances between each compare read and the reference.
- R8: If `var_sum` <= `cfg_var_max`, the run ends with `done`=1, `pass`=1 and `fail`=0.
- R9: Otherwise every word k is written with the complement of reference word k, and the writes complete before `stress_req` rises. `rel_iters` then increments and a new round starts.
- R10: If the variation still exceeds the limit when `rel_iters` equals `cfg_rel_max`, the run ends with `fail`=1 and `fail_phase`=2'b10.
- R11: After reset the block is idle, with `busy`, `done`, `pass`, `fail`, all requests and both array enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (sampled when idle) |
| cfg_win_lo | input | CW | Lowest acceptable ones count |
| cfg_win_hi | input | CW | Highest acceptable ones count |
| cfg_var_max | input | VW | Largest acceptable variation sum |
| cfg_pwrups | input | PCW | Compare power-ups per reliability round |
| cfg_uni_max | input | ITW | Balance-phase stress limit |
| cfg_rel_max | input | ITW | Reliability-phase stress limit |
| arr_addr | output | AW | Array word address |
| arr_rd_en | output | 1 | Array read strobe |
| arr_rdata | input | W | Array read data, one cycle after the strobe |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wdata | output | W | Array write data |
| pwr_req | output | 1 | Power-cycle request |
| pwr_done | input | 1 | Power cycle finished |
| stress_req | output | 1 | Stress-period request |
| stress_done | input | 1 | Stress period finished |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held until next start) |
| pass | output | 1 | Both targets met |
| fail | output | 1 | An iteration limit was reached |
| fail_phase | output | 2 | 01 balance phase, 10 reliability phase |
| uni_iters | output | ITW | Balance-phase stress periods used |
| rel_iters | output | ITW | Reliability-phase stress periods used |
| ones_cnt | output | CW | Ones in latest balance scan |
| var_sum | output | VW | Variation sum of latest reliability round |

## Verification
The hardest situation to reach from the ports is a reliability round whose variation is known exactly and falls as stress is applied. The bench models the array as a clean pattern plus a noise band. The band flips bits in one of two disjoint regions, chosen by the parity of the power-up number. Its width shrinks with each stress period that follows complement writes. As a result, each round's sum is a closed form of the band width and the compare count. At each such stress request, the model also compares the array contents with the complement of the pattern it loaded at the reference power-up.

// File: rtl/puf_tune_pkg.sv
package puf_tune_pkg;

  typedef enum logic [1:0] {
    SM_COUNT = 2'd0,
    SM_REF   = 2'd1,
    SM_CMP   = 2'd2,
    SM_WINV  = 2'd3
  } scan_mode_e;

  typedef enum logic [1:0] {
    PH_NONE = 2'b00,
    PH_UNI  = 2'b01,
    PH_REL  = 2'b10
  } fail_ph_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_U_PWR,
    ST_U_SCAN,
    ST_U_EVAL,
    ST_U_STRESS,
    ST_R_PWR,
    ST_R_SCAN,
    ST_R_EVAL,
    ST_R_WINV,
    ST_R_STRESS
  } seq_state_e;

endpackage

// File: rtl/puf_hs_port.sv
module puf_hs_port (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic done_in,
  output logic req,
  output logic fin
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              req <= 1'b0;
    else if (req && done_in) req <= 1'b0;
    else if (go)             req <= 1'b1;
  end

  // done only counts while the request is pending
  assign fin = req && done_in;

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && !done_in |=> req);
  p_req_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req && done_in && !go |=> !req);

endmodule

// File: rtl/puf_scan_unit.sv
module puf_scan_unit
  import puf_tune_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH * W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  scan_mode_e    mode,
  input  logic [W-1:0]  arr_rdata,
  output logic [AW-1:0] arr_addr,
  output logic          arr_rd_en,
  output logic          arr_wr_en,
  output logic [W-1:0]  arr_wdata,
  output logic          fin,
  output logic [CW-1:0] ones,
  output logic [CW-1:0] diffs
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          active;
  logic [AW-1:0] idx;
  scan_mode_e    mode_q;
  logic          rvld;
  logic [AW-1:0] ridx;
  logic [W-1:0]  ref_mem [DEPTH];

  function automatic logic [CW-1:0] popcnt(input logic [W-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < W; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  assign arr_addr  = idx;
  assign arr_rd_en = active && (mode_q != SM_WINV);
  assign arr_wr_en = active && (mode_q == SM_WINV);
  assign arr_wdata = ~ref_mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      mode_q <= SM_COUNT;
      rvld   <= 1'b0;
      ridx   <= '0;
      fin    <= 1'b0;
      ones   <= '0;
      diffs  <= '0;
    end else begin
      fin  <= 1'b0;
      rvld <= arr_rd_en;
      ridx <= idx;
      if (go) begin
        active <= 1'b1;
        idx    <= '0;
        mode_q <= mode;
        ones   <= '0;
        diffs  <= '0;
      end else if (active) begin
        idx <= idx + AW'(1);
        if (idx == LAST) begin
          active <= 1'b0;
          if (mode_q == SM_WINV) fin <= 1'b1;
        end
      end
      if (rvld) begin
        ones  <= ones + popcnt(arr_rdata);
        diffs <= diffs + popcnt(arr_rdata ^ ref_mem[ridx]);
        if (ridx == LAST) fin <= 1'b1;
      end
    end
  end

  // reference buffer: no reset needed, always written before it is read
  always_ff @(posedge clk) begin
    if (rvld && mode_q == SM_REF) ref_mem[ridx] <= arr_rdata;
  end

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en && $past(arr_rd_en) |-> arr_addr == $past(arr_addr) + AW'(1));
  p_go_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active && !rvld);
  p_wr_rd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_rd_en && arr_wr_en));

endmodule

// File: rtl/puf_tune_seq.sv
module puf_tune_seq
  import puf_tune_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int W        = 8,
  parameter int PCW      = 4,
  parameter int ITW      = 6,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH * W + 1),
  localparam int VW      = CW + PCW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CW-1:0]  cfg_win_lo,
  input  logic [CW-1:0]  cfg_win_hi,
  input  logic [VW-1:0]  cfg_var_max,
  input  logic [PCW-1:0] cfg_pwrups,
  input  logic [ITW-1:0] cfg_uni_max,
  input  logic [ITW-1:0] cfg_rel_max,
  output logic [AW-1:0]  arr_addr,
  output logic           arr_rd_en,
  input  logic [W-1:0]   arr_rdata,
  output logic           arr_wr_en,
  output logic [W-1:0]   arr_wdata,
  output logic           pwr_req,
  input  logic           pwr_done,
  output logic           stress_req,
  input  logic           stress_done,
  output logic           busy,
  output logic           done,
  output logic           pass,
  output logic           fail,
  output logic [1:0]     fail_phase,
  output logic [ITW-1:0] uni_iters,
  output logic [ITW-1:0] rel_iters,
  output logic [CW-1:0]  ones_cnt,
  output logic [VW-1:0]  var_sum
);

  seq_state_e     state;
  logic [CW-1:0]  lo_q, hi_q;
  logic [VW-1:0]  vmax_q;
  logic [PCW-1:0] n_q;
  logic [ITW-1:0] umax_q, rmax_q;
  logic [PCW-1:0] pu_k;
  logic [VW-1:0]  var_acc;

  logic           pwr_go, str_go, scan_go;
  logic           pwr_fin, str_fin, scan_fin;
  scan_mode_e     scan_mode;
  logic [CW-1:0]  scan_ones, scan_diffs;
  logic           in_win, var_ok;

  puf_hs_port u_pwr_hs (
    .clk(clk), .rst_n(rst_n), .go(pwr_go), .done_in(pwr_done),
    .req(pwr_req), .fin(pwr_fin)
  );

  puf_hs_port u_str_hs (
    .clk(clk), .rst_n(rst_n), .go(str_go), .done_in(stress_done),
    .req(stress_req), .fin(str_fin)
  );

  puf_scan_unit #(.DEPTH(DEPTH), .W(W), .AW(AW), .CW(CW)) u_scan (
    .clk(clk), .rst_n(rst_n), .go(scan_go), .mode(scan_mode),
    .arr_rdata(arr_rdata), .arr_addr(arr_addr), .arr_rd_en(arr_rd_en),
    .arr_wr_en(arr_wr_en), .arr_wdata(arr_wdata), .fin(scan_fin),
    .ones(scan_ones), .diffs(scan_diffs)
  );

  assign in_win = (ones_cnt >= lo_q) && (ones_cnt <= hi_q);
  assign var_ok = (var_acc <= vmax_q);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    pwr_go    = 1'b0;
    str_go    = 1'b0;
    scan_go   = 1'b0;
    scan_mode = SM_COUNT;
    unique case (state)
      ST_IDLE:     pwr_go = start;
      ST_U_PWR:    scan_go = pwr_fin;
      ST_U_EVAL: begin
        if (in_win)                  pwr_go = 1'b1;
        else if (uni_iters != umax_q) str_go = 1'b1;
      end
      ST_U_STRESS: pwr_go = str_fin;
      ST_R_PWR: begin
        scan_go   = pwr_fin;
        scan_mode = (pu_k == '0) ? SM_REF : SM_CMP;
      end
      ST_R_SCAN:   pwr_go = scan_fin && (pu_k != n_q);
      ST_R_EVAL: begin
        if (!var_ok && rel_iters != rmax_q) begin
          scan_go   = 1'b1;
          scan_mode = SM_WINV;
        end
      end
      ST_R_WINV:   str_go = scan_fin;
      ST_R_STRESS: pwr_go = str_fin;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      lo_q       <= '0;
      hi_q       <= '0;
      vmax_q     <= '0;
      n_q        <= '0;
      umax_q     <= '0;
      rmax_q     <= '0;
      pu_k       <= '0;
      var_acc    <= '0;
      done       <= 1'b0;
      pass       <= 1'b0;
      fail       <= 1'b0;
      fail_phase <= PH_NONE;
      uni_iters  <= '0;
      rel_iters  <= '0;
      ones_cnt   <= '0;
      var_sum    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          lo_q       <= cfg_win_lo;
          hi_q       <= cfg_win_hi;
          vmax_q     <= cfg_var_max;
          n_q        <= cfg_pwrups;
          umax_q     <= cfg_uni_max;
          rmax_q     <= cfg_rel_max;
          done       <= 1'b0;
          pass       <= 1'b0;
          fail       <= 1'b0;
          fail_phase <= PH_NONE;
          uni_iters  <= '0;
          rel_iters  <= '0;
          var_sum    <= '0;
          state      <= ST_U_PWR;
        end
        ST_U_PWR: if (pwr_fin) state <= ST_U_SCAN;
        ST_U_SCAN: if (scan_fin) begin
          ones_cnt <= scan_ones;
          state    <= ST_U_EVAL;
        end
        ST_U_EVAL: begin
          if (in_win) begin
            pu_k    <= '0;
            var_acc <= '0;
            state   <= ST_R_PWR;
          end else if (uni_iters == umax_q) begin
            fail       <= 1'b1;
            done       <= 1'b1;
            fail_phase <= PH_UNI;
            state      <= ST_IDLE;
          end else begin
            state <= ST_U_STRESS;
          end
        end
        ST_U_STRESS: if (str_fin) begin
          uni_iters <= uni_iters + ITW'(1);
          state     <= ST_U_PWR;
        end
        ST_R_PWR: if (pwr_fin) state <= ST_R_SCAN;
        ST_R_SCAN: if (scan_fin) begin
          if (pu_k != '0) var_acc <= var_acc + VW'(scan_diffs);
          if (pu_k == n_q) begin
            state <= ST_R_EVAL;
          end else begin
            pu_k  <= pu_k + PCW'(1);
            state <= ST_R_PWR;
          end
        end
        ST_R_EVAL: begin
          var_sum <= var_acc;
          if (var_ok) begin
            pass  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (rel_iters == rmax_q) begin
            fail       <= 1'b1;
            done       <= 1'b1;
            fail_phase <= PH_REL;
            state      <= ST_IDLE;
          end else begin
            state <= ST_R_WINV;
          end
        end
        ST_R_WINV: if (scan_fin) state <= ST_R_STRESS;
        ST_R_STRESS: if (str_fin) begin
          rel_iters <= rel_iters + ITW'(1);
          pu_k      <= '0;
          var_acc   <= '0;
          state     <= ST_R_PWR;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_req && stress_req));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pwr_req && !stress_req && !arr_rd_en && !arr_wr_en);
  p_done_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));
  p_fail_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> fail_phase != 2'b00);
  p_uni_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> uni_iters <= umax_q);
  p_rel_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rel_iters <= rmax_q);
  p_no_write_uni_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |-> state == ST_R_WINV);

endmodule

// File: tb/puf_tune_seq_bench.sv
module puf_tune_seq_bench;

  localparam int DEPTH = 16;
  localparam int W     = 8;
  localparam int NB    = DEPTH * W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cfg_win_lo = '0, cfg_win_hi = '0;
  logic [11:0] cfg_var_max = '0;
  logic [3:0] cfg_pwrups = '0;
  logic [5:0] cfg_uni_max = '0, cfg_rel_max = '0;
  logic [3:0] arr_addr;
  logic       arr_rd_en, arr_wr_en;
  logic [W-1:0] arr_rdata = '0, arr_wdata;
  logic       pwr_req, stress_req;
  logic       pwr_done_r = 1'b0, stress_done_r = 1'b0;
  logic       g_pwr = 1'b0, g_str = 1'b0;
  logic       busy, done, pass, fail;
  logic [1:0] fail_phase;
  logic [5:0] uni_iters, rel_iters;
  logic [7:0] ones_cnt;
  logic [11:0] var_sum;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  puf_tune_seq u_puf_tune_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi), .cfg_var_max(cfg_var_max),
    .cfg_pwrups(cfg_pwrups), .cfg_uni_max(cfg_uni_max), .cfg_rel_max(cfg_rel_max),
    .arr_addr(arr_addr), .arr_rd_en(arr_rd_en), .arr_rdata(arr_rdata),
    .arr_wr_en(arr_wr_en), .arr_wdata(arr_wdata),
    .pwr_req(pwr_req), .pwr_done(pwr_done_r | g_pwr),
    .stress_req(stress_req), .stress_done(stress_done_r | g_str),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .fail_phase(fail_phase),
    .uni_iters(uni_iters), .rel_iters(rel_iters), .ones_cnt(ones_cnt), .var_sum(var_sum)
  );

  // ---- array and power/stress model ----
  logic       model_rst = 1'b0;
  int m_ones = 64, m_delta = 0, m_noise = 0, m_rstep = 0, m_n = 0;
  int ones_now, noise_n, pu_idx, n_uni, n_rel, cmp_err, pcnt, scnt, bad;
  logic wrote;
  logic [W-1:0] mem  [DEPTH];
  logic [W-1:0] hist [8][DEPTH];

  function automatic logic [W-1:0] pat_word(int wi, int pidx, int on, int nz);
    logic [W-1:0] v;
    int off;
    off = (pidx % 2 == 1) ? 64 : 0;
    for (int j = 0; j < W; j++) begin
      int b;
      b = wi * W + j;
      v[j] = (b < on) ^ (b >= off && b < off + nz);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    pwr_done_r    <= 1'b0;
    stress_done_r <= 1'b0;
    if (model_rst) begin
      pu_idx <= 0; ones_now <= m_ones; noise_n <= m_noise;
      n_uni <= 0; n_rel <= 0; cmp_err <= 0; wrote <= 1'b0; pcnt <= 0; scnt <= 0;
    end else begin
      if (arr_wr_en) begin
        mem[arr_addr] <= arr_wdata;
        wrote <= 1'b1;
      end
      if (arr_rd_en) arr_rdata <= mem[arr_addr];
      if (pwr_req && !pwr_done_r) begin
        if (pcnt == 3) begin
          pcnt <= 0;
          for (int wi = 0; wi < DEPTH; wi++) begin
            mem[wi] <= pat_word(wi, pu_idx, ones_now, noise_n);
            hist[pu_idx % 8][wi] <= pat_word(wi, pu_idx, ones_now, noise_n);
          end
          pu_idx <= pu_idx + 1;
          wrote <= 1'b0;
          pwr_done_r <= 1'b1;
        end else pcnt <= pcnt + 1;
      end
      if (stress_req && !stress_done_r) begin
        if (scnt == 2) begin
          scnt <= 0;
          if (wrote) begin
            bad = 0;
            for (int wi = 0; wi < DEPTH; wi++)
              if (mem[wi] !== ~hist[(pu_idx - 1 - m_n) % 8][wi]) bad = bad + 1;
            cmp_err <= cmp_err + bad;
            noise_n <= (noise_n > m_rstep) ? noise_n - m_rstep : 0;
            n_rel <= n_rel + 1;
          end else begin
            ones_now <= ones_now + m_delta;
            n_uni <= n_uni + 1;
          end
          stress_done_r <= 1'b1;
        end else scnt <= scnt + 1;
      end
    end
  end

  // ---- helpers ----
  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic launch(input int lo, hi, vmax, n, umax, rmax,
                        input int ones, delta, noise, rstep);
    m_ones = ones; m_delta = delta; m_noise = noise; m_rstep = rstep; m_n = n;
    @(negedge clk); model_rst = 1'b1;
    @(negedge clk); model_rst = 1'b0;
    cfg_win_lo = 8'(lo); cfg_win_hi = 8'(hi); cfg_var_max = 12'(vmax);
    cfg_pwrups = 4'(n); cfg_uni_max = 6'(umax); cfg_rel_max = 6'(rmax);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check("R8 run completes", int'(done), 1);
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    check("R11 busy", int'(busy), 0);
    check("R11 done", int'(done), 0);
    check("R11 pass/fail", int'(pass | fail), 0);
    check("R11 requests", int'(pwr_req | stress_req), 0);
    check("R11 array strobes", int'(arr_rd_en | arr_wr_en), 0);
  endtask

  task automatic t_balanced();
    launch(56, 72, 0, 2, 4, 4, 64, 0, 0, 0);
    while (!pwr_req) @(negedge clk);
    g_str = 1'b1; @(negedge clk); g_str = 1'b0;   // R2 stray done, no request
    wait_done();
    check("R4 no balance stress", n_uni, 0);
    check("R4 uni_iters", int'(uni_iters), 0);
    check("R3 ones_cnt", int'(ones_cnt), 64);
    check("R8 pass", int'(pass), 1);
    check("R7 var_sum", int'(var_sum), 0);
    check("R7 power-ups", pu_idx, 4);
    check("R2 stray done ignored", int'(stress_req), 0);
  endtask

  task automatic t_skewed();
    launch(56, 72, 0, 2, 8, 4, 100, -12, 0, 0);
    repeat (5) @(negedge clk);
    cfg_win_lo = 8'd0; cfg_win_hi = 8'd128; cfg_uni_max = 6'd0;  // R1 must be ignored
    start = 1'b1; @(negedge clk); start = 1'b0;                  // R1 start while busy
    wait_done();
    check("R5 balance stresses", n_uni, 3);
    check("R5 uni_iters", int'(uni_iters), 3);
    check("R3 ones_cnt after tuning", int'(ones_cnt), 64);
    check("R1 config held", int'(pass), 1);
    check("R7 power-ups", pu_idx, 7);
  endtask

  task automatic t_bounds();
    launch(56, 72, 0, 2, 8, 4, 50, 3, 0, 0);
    wait_done();
    check("R4 low bound inclusive stresses", n_uni, 2);
    check("R3 ones_cnt at low bound", int'(ones_cnt), 56);
    launch(56, 72, 0, 2, 8, 4, 72, -3, 0, 0);
    wait_done();
    check("R4 high bound inclusive", int'(uni_iters), 0);
    check("R4 high bound pass", int'(pass), 1);
  endtask

  task automatic t_uni_fail();
    launch(56, 72, 0, 2, 2, 4, 120, -4, 0, 0);
    wait_done();
    check("R6 fail", int'(fail), 1);
    check("R6 pass low", int'(pass), 0);
    check("R6 phase code", int'(fail_phase), 1);
    check("R6 uni_iters", int'(uni_iters), 2);
    check("R6 ones_cnt", int'(ones_cnt), 112);
    check("R7 no reliability power-ups", pu_idx, 3);
  endtask

  task automatic t_reliability();
    launch(56, 72, 4, 2, 4, 5, 64, 0, 6, 3);
    wait_done();
    check("R3 ones_cnt with noise", int'(ones_cnt), 58);
    check("R9 rel_iters", int'(rel_iters), 2);
    check("R9 reliability stresses", n_rel, 2);
    check("R9 complement written", cmp_err, 0);
    check("R8 pass", int'(pass), 1);
    check("R7 final var_sum", int'(var_sum), 0);
    check("R7 power-ups", pu_idx, 10);
  endtask

  task automatic t_rel_fail();
    launch(56, 72, 2, 4, 4, 1, 64, 0, 8, 1);
    wait_done();
    check("R10 fail", int'(fail), 1);
    check("R10 phase code", int'(fail_phase), 2);
    check("R10 rel_iters", int'(rel_iters), 1);
    check("R7 var_sum measured", int'(var_sum), 28);
    check("R9 complement written", cmp_err, 0);
    check("R3 ones_cnt", int'(ones_cnt), 56);
  endtask

  task automatic t_idle_done();
    @(negedge clk);
    g_pwr = 1'b1; g_str = 1'b1;
    @(negedge clk);
    g_pwr = 1'b0; g_str = 1'b0;
    @(negedge clk);
    check("R2 idle done ignored busy", int'(busy), 0);
    check("R2 idle done ignored req", int'(pwr_req | stress_req), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_done();
    t_balanced();
    t_skewed();
    t_bounds();
    t_uni_fail();
    t_reliability();
    t_rel_fail();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule